// File: doc/BRIEF.md
# Synonym Snoop Probe Engine

This block keeps a virtually indexed, physically tagged cache coherent with writes seen on a shared bus. The cache has more sets than one page can address. A physical line can therefore be held at any of several indexes, and those indexes differ only in the upper index bits, which come from the virtual address. The bus carries only the physical address. For this reason the engine does not look up a reverse translation. It walks every candidate index in turn, reads the physical tags of all ways, and clears the valid bit of every way whose tag matches.

A snoop request is accepted through a valid/ready handshake, and the address is captured at that moment. The engine issues one tag-array read per cycle. The candidate count is a power of two set by a parameter: eight sets for a data cache, four for an instruction cache. The tag array answers one cycle after each read. Invalidations go out on a separate strobe with an index and a way mask. The whole probe takes a fixed number of cycles, so a system can place it inside the memory response window of the bus write. A one-cycle completion pulse marks the end of every probe, with or without a match.

Top module: `snoop_alias_probe`

## Requirements
- R1: Under reset and until the first accepted request, `busy_o`, `done_o`, `tag_rd_en_o` and `tag_inv_o` are low and `snp_ready_o` is high.
- R2: In the cycle after acceptance the engine starts reading one candidate per cycle for 2^VIDX_W cycles. The candidate index is {count, addr[LINE_W +: PIDX_W]}, the count occupies the upper VIDX_W index bits, and it rises from 0 to 2^VIDX_W-1.
- R3: The tag array answers a read in the following cycle. In that cycle the engine raises `tag_inv_o` when at least one valid way holds the tag addr[PA_W-1 -: TAG_W]. It also drives `tag_inv_idx_o` with the index that was read and `tag_inv_way_o` with bit w set for each matching way w.
- R4: A way whose valid bit is clear, or whose tag differs, is never invalidated. Entries at other page-offset indexes are never touched.
- R5: A single snoop invalidates every copy of the line, even when the copies sit at several candidate indexes or in both ways of one set.
- R6: `done_o` is high for exactly one cycle, 2^VIDX_W+1 cycles after the acceptance edge, in the cycle after the last read. This happens whether or not any tag matched.
- R7: `snp_ready_o` is the inverse of `busy_o`. `busy_o` stays high from the cycle after acceptance through the `done_o` cycle. A request that arrives while the engine is busy waits until ready returns and is then accepted.
- R8: The snoop address is sampled only when a request is accepted. Changes on `snp_addr_i` during a probe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Snoop request valid |
| snp_ready_o | output | 1 | Engine can accept a request |
| snp_addr_i | input | PA_W | Physical byte address of the bus write |
| tag_rd_en_o | output | 1 | Tag array read strobe |
| tag_rd_idx_o | output | PIDX_W+VIDX_W | Set index to read |
| tag_rd_vld_i | input | WAYS | Valid bits of the read set, one cycle after the strobe |
| tag_rd_tag_i | input | WAYS*TAG_W | Physical tags of the read set, way w at bits [w*TAG_W +: TAG_W] |
| tag_inv_o | output | 1 | Invalidate strobe |
| tag_inv_idx_o | output | PIDX_W+VIDX_W | Set index to invalidate |
| tag_inv_way_o | output | WAYS | Ways to invalidate |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle pulse at probe completion |

## Verification
The bench plants one physical line at two alias indexes, in different ways, together with decoys. The decoys are a same-tag copy with its valid bit clear, a different tag in an alias set, and the same tag under a different page-offset index. A design that stopped after the first hit, or never widened the search past the page bits, would leave a stale copy valid. A design that ignored the valid bit, or mixed up the page-offset bits, would remove a decoy. A set with both ways matching checks the way mask. A snoop with no match checks that completion still comes at the fixed cycle. A request held against a busy engine checks that the second snoop waits and does not corrupt the first. The snoop address is scrambled after each acceptance to catch a design that keeps reading the live input.

// File: rtl/snp_probe_pkg.sv
package snp_probe_pkg;
  localparam int unsigned DEF_PA_W   = 20;
  localparam int unsigned DEF_LINE_W = 5;
  localparam int unsigned DEF_PIDX_W = 7;
  localparam int unsigned DEF_VIDX_W = 3;  // 3: data cache, 2: instruction cache
  localparam int unsigned DEF_WAYS   = 2;

  function automatic int unsigned cand_count(int unsigned vidx_w);
    return 32'd1 << vidx_w;
  endfunction
endpackage

// File: rtl/snp_cand_gen.sv
module snp_cand_gen #(
  parameter int unsigned PIDX_W = 7,
  parameter int unsigned VIDX_W = 3,
  localparam int unsigned IDX_W = PIDX_W + VIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PIDX_W-1:0] pidx_i,
  output logic              active_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [VIDX_W-1:0] CNT_MAX = {VIDX_W{1'b1}};

  logic [VIDX_W-1:0] cnt_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == CNT_MAX) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + VIDX_W'(1);
    end
  end

  // virtual-only bits sweep, page-offset bits held
  assign idx_o    = {cnt_q, pidx_i};
  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == CNT_MAX);
endmodule

// File: rtl/snp_way_cmp.sv
module snp_way_cmp #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 8
) (
  input  logic                  en_i,
  input  logic [WAYS-1:0]       vld_i,
  input  logic [WAYS*TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]      ref_i,
  output logic [WAYS-1:0]       hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = en_i && vld_i[w] && (tag_i[w*TAG_W +: TAG_W] == ref_i);
  end
endmodule

// File: rtl/snoop_alias_probe.sv
module snoop_alias_probe
  import snp_probe_pkg::*;
#(
  parameter int unsigned PA_W   = DEF_PA_W,
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned PIDX_W = DEF_PIDX_W,
  parameter int unsigned VIDX_W = DEF_VIDX_W,
  parameter int unsigned WAYS   = DEF_WAYS,
  localparam int unsigned TAG_W = PA_W - LINE_W - PIDX_W,
  localparam int unsigned IDX_W = PIDX_W + VIDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  snp_valid_i,
  output logic                  snp_ready_o,
  input  logic [PA_W-1:0]       snp_addr_i,
  output logic                  tag_rd_en_o,
  output logic [IDX_W-1:0]      tag_rd_idx_o,
  input  logic [WAYS-1:0]       tag_rd_vld_i,
  input  logic [WAYS*TAG_W-1:0] tag_rd_tag_i,
  output logic                  tag_inv_o,
  output logic [IDX_W-1:0]      tag_inv_idx_o,
  output logic [WAYS-1:0]       tag_inv_way_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic [PA_W-1:0]  addr_q;
  logic             accept;
  logic             gen_active, gen_last;
  logic [IDX_W-1:0] gen_idx;
  logic             cmp_vld_q, cmp_last_q;
  logic [IDX_W-1:0] cmp_idx_q;
  logic [WAYS-1:0]  hit;

  assign accept = snp_valid_i && snp_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= snp_addr_i;
  end

  snp_cand_gen #(.PIDX_W(PIDX_W), .VIDX_W(VIDX_W)) u_cand (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .pidx_i   (addr_q[LINE_W +: PIDX_W]),
    .active_o (gen_active),
    .last_o   (gen_last),
    .idx_o    (gen_idx)
  );

  // compare stage lines up with the array's one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_vld_q  <= 1'b0;
      cmp_last_q <= 1'b0;
      cmp_idx_q  <= '0;
    end else begin
      cmp_vld_q  <= gen_active;
      cmp_last_q <= gen_last;
      cmp_idx_q  <= gen_idx;
    end
  end

  snp_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .en_i  (cmp_vld_q),
    .vld_i (tag_rd_vld_i),
    .tag_i (tag_rd_tag_i),
    .ref_i (addr_q[PA_W-1 -: TAG_W]),
    .hit_o (hit)
  );

  assign tag_rd_en_o   = gen_active;
  assign tag_rd_idx_o  = gen_idx;
  assign tag_inv_o     = |hit;
  assign tag_inv_idx_o = cmp_idx_q;
  assign tag_inv_way_o = hit;
  assign busy_o        = gen_active || cmp_vld_q;
  assign snp_ready_o   = !busy_o;
  assign done_o        = cmp_vld_q && cmp_last_q;

  // R7
  start_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(snp_valid_i));

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  // R2
  sweep_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_rd_en_o) |-> tag_rd_idx_o[IDX_W-1 -: VIDX_W] == '0);

  // R2
  sweep_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_rd_en_o && $past(tag_rd_en_o) |->
      (tag_rd_idx_o[IDX_W-1 -: VIDX_W] == $past(tag_rd_idx_o[IDX_W-1 -: VIDX_W]) + VIDX_W'(1)) &&
      (tag_rd_idx_o[PIDX_W-1:0] == $past(tag_rd_idx_o[PIDX_W-1:0])));

  // R3
  inv_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_inv_o |-> $past(tag_rd_en_o) && (tag_inv_idx_o == $past(tag_rd_idx_o)));

  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tag_rd_en_o) && !tag_rd_en_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);
endmodule

// File: tb/snoop_alias_probe_tb_top.sv
module snoop_alias_probe_tb_top;
  localparam int PA_W = 20, LINE_W = 5, PIDX_W = 7, VIDX_W = 3, WAYS = 2;
  localparam int TAG_W = PA_W - LINE_W - PIDX_W;
  localparam int IDX_W = PIDX_W + VIDX_W;
  localparam int NSETS = 1 << IDX_W;
  localparam int NCAND = 1 << VIDX_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic                  snp_valid_i = 1'b0;
  logic                  snp_ready_o;
  logic [PA_W-1:0]       snp_addr_i = '0;
  logic                  tag_rd_en_o;
  logic [IDX_W-1:0]      tag_rd_idx_o;
  logic [WAYS-1:0]       tag_rd_vld_i;
  logic [WAYS*TAG_W-1:0] tag_rd_tag_i;
  logic                  tag_inv_o;
  logic [IDX_W-1:0]      tag_inv_idx_o;
  logic [WAYS-1:0]       tag_inv_way_o;
  logic                  busy_o, done_o;

  snoop_alias_probe dut_i (.*);

  // tag array model
  logic [WAYS-1:0]       m_vld [NSETS];
  logic [WAYS*TAG_W-1:0] m_tag [NSETS];
  logic                  pl_en = 1'b0, pl_way = 1'b0, pl_vld = 1'b0;
  logic [IDX_W-1:0]      pl_idx = '0;
  logic [TAG_W-1:0]      pl_tag = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSETS; i++) m_vld[i] <= '0;
      tag_rd_vld_i <= '0;
      tag_rd_tag_i <= '0;
    end else begin
      if (tag_rd_en_o) begin
        tag_rd_vld_i <= m_vld[tag_rd_idx_o];
        tag_rd_tag_i <= m_tag[tag_rd_idx_o];
      end
      if (tag_inv_o) m_vld[tag_inv_idx_o] <= m_vld[tag_inv_idx_o] & ~tag_inv_way_o;
      if (pl_en) begin
        m_vld[pl_idx][pl_way] <= pl_vld;
        m_tag[pl_idx][pl_way*TAG_W +: TAG_W] <= pl_tag;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [WAYS-1:0]  way;
  } inv_t;
  inv_t exp_q[$];
  inv_t got;

  always @(negedge clk_i) begin
    if (rst_ni && tag_inv_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected invalidate", {tag_inv_idx_o, tag_inv_way_o}, 0);
      else begin
        got = exp_q.pop_front();
        chk(got.idx == tag_inv_idx_o && got.way == tag_inv_way_o, "R3 R5", "invalidate idx/way",
            {tag_inv_idx_o, tag_inv_way_o}, {got.idx, got.way});
      end
    end
  end

  function automatic logic [PA_W-1:0] mk(input logic [TAG_W-1:0] t, input logic [PIDX_W-1:0] p);
    return {t, p, 5'h0a};
  endfunction

  function automatic logic [IDX_W-1:0] ix(input int vb, input logic [PIDX_W-1:0] p);
    return {vb[VIDX_W-1:0], p};
  endfunction

  task automatic expect_snoop(input logic [PA_W-1:0] a);
    for (int c = 0; c < NCAND; c++) begin
      inv_t e;
      e.idx = ix(c, a[LINE_W +: PIDX_W]);
      for (int w = 0; w < WAYS; w++)
        e.way[w] = m_vld[e.idx][w] && (m_tag[e.idx][w*TAG_W +: TAG_W] == a[PA_W-1 -: TAG_W]);
      if (e.way != '0) exp_q.push_back(e);
    end
  endtask

  task automatic plant(input logic [IDX_W-1:0] i, input logic w, input logic [TAG_W-1:0] t, input logic v);
    @(negedge clk_i);
    pl_en = 1'b1; pl_idx = i; pl_way = w; pl_tag = t; pl_vld = v;
    @(negedge clk_i);
    pl_en = 1'b0;
  endtask

  task automatic launch(input logic [PA_W-1:0] a);
    @(negedge clk_i);
    snp_valid_i = 1'b1; snp_addr_i = a;
    while (!snp_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    snp_valid_i = 1'b0;
    snp_addr_i  = ~a;  // R8: must not matter after acceptance
  endtask

  // entered at the first negedge after acceptance
  task automatic sweep_check(input logic [PIDX_W-1:0] p);
    bit seq_ok = 1'b1, pidx_ok = 1'b1;
    for (int k = 1; k <= NCAND; k++) begin
      if (k > 1) @(negedge clk_i);
      if (!(tag_rd_en_o && busy_o && !done_o && tag_rd_idx_o[IDX_W-1 -: VIDX_W] == VIDX_W'(k-1))) seq_ok = 1'b0;
      if (tag_rd_idx_o[PIDX_W-1:0] != p) pidx_ok = 1'b0;
    end
    chk(seq_ok, "R2", "candidate sequence", tag_rd_idx_o, ix(NCAND-1, p));
    chk(pidx_ok, "R8", "page bits from captured address", tag_rd_idx_o[PIDX_W-1:0], p);
    @(negedge clk_i);
    chk(done_o && !tag_rd_en_o && busy_o, "R6", "done at last compare", {done_o, tag_rd_en_o, busy_o}, 3'b101);
    @(negedge clk_i);
    chk(!busy_o && snp_ready_o && !done_o, "R7", "idle after done", {busy_o, snp_ready_o, done_o}, 3'b010);
  endtask

  localparam logic [TAG_W-1:0] TA = 8'h5c, TB = 8'h33, TC = 8'hc1, TD = 8'h71, TE = 8'h0e, TN = 8'h99;
  localparam logic [PIDX_W-1:0] PA = 7'h15, PB = 7'h16, PC = 7'h20, PD = 7'h30, PE = 7'h31;

  initial begin
    #35;
    // R1
    chk(!busy_o && snp_ready_o && !done_o && !tag_rd_en_o && !tag_inv_o, "R1", "outputs in reset",
        {busy_o, snp_ready_o, done_o, tag_rd_en_o, tag_inv_o}, 5'b01000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk(!busy_o && snp_ready_o && !done_o && !tag_rd_en_o && !tag_inv_o, "R1", "outputs after reset",
        {busy_o, snp_ready_o, done_o, tag_rd_en_o, tag_inv_o}, 5'b01000);

    // aliases plus decoys
    plant(ix(1, PA), 1'b0, TA, 1'b1);
    plant(ix(6, PA), 1'b1, TA, 1'b1);
    plant(ix(3, PA), 1'b0, TB, 1'b1);
    plant(ix(4, PA), 1'b1, TA, 1'b0);
    plant(ix(2, PB), 1'b0, TA, 1'b1);
    plant(ix(6, PA), 1'b0, TB, 1'b1);
    expect_snoop(mk(TA, PA));
    chk(exp_q.size() == 2, "R5", "expected alias hits", exp_q.size(), 2);
    launch(mk(TA, PA));
    sweep_check(PA);
    chk(m_vld[ix(1, PA)][0] == 1'b0, "R5", "alias copy 1 cleared", m_vld[ix(1, PA)][0], 0);
    chk(m_vld[ix(6, PA)][1] == 1'b0, "R5", "alias copy 2 cleared", m_vld[ix(6, PA)][1], 0);
    chk(m_vld[ix(3, PA)][0] == 1'b1, "R4", "other tag kept", m_vld[ix(3, PA)][0], 1);
    chk(m_vld[ix(6, PA)][0] == 1'b1, "R4", "other way kept", m_vld[ix(6, PA)][0], 1);
    chk(m_vld[ix(2, PB)][0] == 1'b1, "R4", "other page index kept", m_vld[ix(2, PB)][0], 1);
    chk(m_vld[ix(4, PA)][1] == 1'b0, "R4", "invalid way stays invalid", m_vld[ix(4, PA)][1], 0);

    // both ways of the last set
    plant(ix(7, PC), 1'b0, TC, 1'b1);
    plant(ix(7, PC), 1'b1, TC, 1'b1);
    expect_snoop(mk(TC, PC));
    launch(mk(TC, PC));
    sweep_check(PC);
    chk(m_vld[ix(7, PC)] == 2'b00, "R3", "both ways cleared", m_vld[ix(7, PC)], 0);

    // no match
    expect_snoop(mk(TN, PC));
    chk(exp_q.size() == 0, "R6", "no-match setup", exp_q.size(), 0);
    launch(mk(TN, PC));
    sweep_check(PC);

    // request held off while busy
    plant(ix(0, PD), 1'b0, TD, 1'b1);
    plant(ix(5, PE), 1'b1, TE, 1'b1);
    expect_snoop(mk(TD, PD));
    expect_snoop(mk(TE, PE));
    begin
      bit held = 1'b1;
      @(negedge clk_i);
      snp_valid_i = 1'b1; snp_addr_i = mk(TD, PD);
      while (!snp_ready_o) @(negedge clk_i);
      @(posedge clk_i);
      @(negedge clk_i);
      snp_addr_i = mk(TE, PE);
      for (int k = 1; k <= NCAND + 1; k++) begin
        if (k > 1) @(negedge clk_i);
        if (snp_ready_o) held = 1'b0;
        if (k == NCAND + 1) chk(done_o, "R6", "first probe done while second waits", done_o, 1);
      end
      chk(held, "R7", "second request held off", held, 1);
      @(negedge clk_i);
      chk(snp_ready_o, "R7", "ready after done", snp_ready_o, 1);
      @(posedge clk_i);
      @(negedge clk_i);
      snp_valid_i = 1'b0; snp_addr_i = '0;
      sweep_check(PE);
    end
    chk(m_vld[ix(0, PD)][0] == 1'b0 && m_vld[ix(5, PE)][1] == 1'b0, "R7", "both queued snoops applied",
        {m_vld[ix(0, PD)][0], m_vld[ix(5, PE)][1]}, 0);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R5", "all expected invalidates seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule